// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block turns single memory requests from a processor core into expanded bus cycles of the classic multiplexed 8-bit style. It handles three kinds of cycle: an instruction fetch, a data read and a data write. Each cycle places the upper address byte on a dedicated port. The lower address byte and the data byte take turns on one shared port with an output enable. An address-latch strobe lets an external transparent latch capture the lower address before that port changes to data.

Every edge of the cycle is placed on a grid of oscillator clocks. One oscillator clock is one system clock in which `osc_tick` is high. A fetch spans 6 oscillator clocks and a data cycle spans 12. Read and fetch data are sampled from the shared port in the last oscillator clock of the active strobe and returned with a one-clock `rsp_valid` pulse. The block accepts a new request only in an oscillator clock where `req_ready` is high. Because it is also ready in the final oscillator clock of a cycle, cycles can follow each other with no gap.

Top module: `ebus_cycle_seq`

## Requirements
- R1: While reset is high, and whenever no cycle is running, `ale` is low, `fetch_n`, `rd_n` and `wr_n` are high, `ad_oe` is low and `req_ready` is high.
- R2: In each cycle, the oscillator clocks are numbered from 0 starting at the one after acceptance. `ale` is high in clocks 0 and 1 only. The lower address byte is driven on `ad_out` with `ad_oe` high in clocks 0 to 2.
- R3: `req_kind` 2'b00 is a fetch. It lasts 6 oscillator clocks, and `fetch_n` is low in clocks 3 to 5 only.
- R4: `req_kind` 2'b01 (and 2'b11) is a data read, with `rd_n` low in clocks 5 to 10. 2'b10 is a data write, with `wr_n` low in clocks 5 to 10. Both last 12 oscillator clocks, so `ale` of a following cycle rises one oscillator clock after the strobe rises.
- R5: On a write, the data byte is on `ad_out` with `ad_oe` high from clock 3 through clock 11.
- R6: On a fetch or a read, `ad_oe` is low from clock 3 to the end of the cycle, so the port is released by the time the strobe falls.
- R7: `addr_hi` carries the upper byte of the accepted address throughout the cycle.
- R8: On a fetch or read, `ad_in` is captured at the end of the last strobe-low oscillator clock (clock 5 for a fetch, clock 10 for a read). `rsp_valid` is then high for exactly one system clock with that byte on `rsp_data`. A write produces no `rsp_valid`.
- R9: `req_ready` is high only when idle or in the last oscillator clock of a cycle. A request presented while `req_ready` is low, or without `osc_tick`, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-clock enable marking an oscillator clock |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data byte |
| req_ready | output | 1 | Request is taken on this oscillator clock |
| ale | output | 1 | Address latch enable, active high |
| fetch_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared port outgoing value |
| ad_oe | output | 1 | Shared port drive enable |
| ad_in | input | 8 | Shared port incoming value |
| rsp_data | output | 8 | Captured fetch or read byte |
| rsp_valid | output | 1 | One-clock pulse with rsp_data |

## Verification
The first directed pattern uses an oscillator tick in every clock and a request that stays valid, cycling through all four kind codes. This exercises back-to-back cycles, where a wrong cycle length or a wrong ready slot shifts every later strobe. The random pattern gives `osc_tick` a random duty and presents random requests while busy. It separates edges placed by oscillator clock from edges placed by system clock, and shows whether refused requests leak into the sequence. A bench-side external latch and memory answer reads, so wrong capture timing or a late port release shows up as wrong returned bytes.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
   typedef enum logic [1:0] {
      KIND_FETCH = 2'b00,
      KIND_READ  = 2'b01,
      KIND_WRITE = 2'b10,
      KIND_READX = 2'b11
   } ebus_kind_e;

   function automatic logic kind_is_write(input ebus_kind_e k);
      return k == KIND_WRITE;
   endfunction

   function automatic logic kind_is_fetch(input ebus_kind_e k);
      return k == KIND_FETCH;
   endfunction
endpackage

// File: rtl/ebus_slot_timer.sv
module ebus_slot_timer #(
   parameter int SLOT_W    = 4,
   parameter int FETCH_LEN = 6,
   parameter int DATA_LEN  = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              osc_tick,
   input  logic              start,
   input  logic              start_long,
   output logic              busy,
   output logic [SLOT_W-1:0] slot,
   output logic              last
);
   localparam logic [SLOT_W-1:0] FETCH_END = SLOT_W'(FETCH_LEN - 1);
   localparam logic [SLOT_W-1:0] DATA_END  = SLOT_W'(DATA_LEN - 1);

   logic              busy_q;
   logic              long_q;
   logic [SLOT_W-1:0] slot_q;

   assign busy = busy_q;
   assign slot = slot_q;
   assign last = busy_q && (slot_q == (long_q ? DATA_END : FETCH_END));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         long_q <= 1'b0;
         slot_q <= '0;
      end else if (osc_tick) begin
         if (start) begin
            busy_q <= 1'b1;
            long_q <= start_long;
            slot_q <= '0;
         end else if (last) begin
            busy_q <= 1'b0;
            slot_q <= '0;
         end else if (busy_q) begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   // R3 R4
   slot_range_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_q && !long_q) |-> (slot_q <= FETCH_END));
endmodule

// File: rtl/ebus_strobe_gen.sv
module ebus_strobe_gen
   import ebus_pkg::*;
#(
   parameter int SLOT_W    = 4,
   parameter int ALE_W     = 2,
   parameter int ADDR_HOLD = 1,
   parameter int PSEN_DLY  = 1,
   parameter int PSEN_W    = 3,
   parameter int STB_DLY   = 3,
   parameter int STB_W     = 6
) (
   input  logic              busy,
   input  ebus_kind_e        kind,
   input  logic [SLOT_W-1:0] slot,
   output logic              ale,
   output logic              fetch_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic              drive_en,
   output logic              drive_data,
   output logic              sample
);
   localparam logic [SLOT_W-1:0] ALE_END  = SLOT_W'(ALE_W - 1);
   localparam logic [SLOT_W-1:0] ADDR_END = SLOT_W'(ALE_W + ADDR_HOLD - 1);
   localparam logic [SLOT_W-1:0] PS_LO    = SLOT_W'(ALE_W + PSEN_DLY);
   localparam logic [SLOT_W-1:0] PS_HI    = SLOT_W'(ALE_W + PSEN_DLY + PSEN_W - 1);
   localparam logic [SLOT_W-1:0] ST_LO    = SLOT_W'(ALE_W + STB_DLY);
   localparam logic [SLOT_W-1:0] ST_HI    = SLOT_W'(ALE_W + STB_DLY + STB_W - 1);
   localparam logic [SLOT_W-1:0] WD_END   = SLOT_W'(ALE_W + STB_DLY + STB_W);

   logic is_fetch, is_write, is_read;
   logic in_addr, in_ps, in_st;

   always_comb begin
      is_fetch = busy && kind_is_fetch(kind);
      is_write = busy && kind_is_write(kind);
      is_read  = busy && !kind_is_fetch(kind) && !kind_is_write(kind);
      in_addr  = slot <= ADDR_END;
      in_ps    = (slot >= PS_LO) && (slot <= PS_HI);
      in_st    = (slot >= ST_LO) && (slot <= ST_HI);

      ale        = busy && (slot <= ALE_END);
      fetch_n    = !(is_fetch && in_ps);
      rd_n       = !(is_read && in_st);
      wr_n       = !(is_write && in_st);
      drive_data = is_write && !in_addr && (slot <= WD_END);
      drive_en   = (busy && in_addr) || drive_data;
      sample     = (is_fetch && slot == PS_HI) || (is_read && slot == ST_HI);
   end
endmodule

// File: rtl/ebus_ad_port.sv
module ebus_ad_port #(
   parameter int DATA_W        = 8,
   parameter bit DONE_ON_WRITE = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              drive_en,
   input  logic              drive_data,
   input  logic [DATA_W-1:0] addr_lo,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] ad_in,
   input  logic              capture,
   input  logic              write_end,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_valid
);
   logic done_src;

   assign ad_oe  = drive_en;
   assign ad_out = drive_data ? wdata : addr_lo;

   generate
      if (DONE_ON_WRITE) begin : g_done_all
         assign done_src = capture || write_end;
      end else begin : g_done_rd
         assign done_src = capture;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_data  <= '0;
         rsp_valid <= 1'b0;
      end else begin
         rsp_valid <= done_src;
         if (capture) rsp_data <= ad_in;
      end
   end

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/ebus_cycle_seq.sv
module ebus_cycle_seq
   import ebus_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int ALE_W         = 2,
   parameter int ADDR_HOLD     = 1,
   parameter int PSEN_DLY      = 1,
   parameter int PSEN_W        = 3,
   parameter int STB_DLY       = 3,
   parameter int STB_W         = 6,
   parameter bit DONE_ON_WRITE = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     osc_tick,
   input  logic                     req_valid,
   input  logic [1:0]               req_kind,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     req_ready,
   output logic                     ale,
   output logic                     fetch_n,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe,
   input  logic [DATA_W-1:0]        ad_in,
   output logic [DATA_W-1:0]        rsp_data,
   output logic                     rsp_valid
);
   localparam int FETCH_LEN = ALE_W + PSEN_DLY + PSEN_W;
   localparam int DATA_LEN  = ALE_W + STB_DLY + STB_W + 1;
   localparam int CYC_MAX   = (FETCH_LEN > DATA_LEN) ? FETCH_LEN : DATA_LEN;
   localparam int SLOT_W    = $clog2(CYC_MAX + 1);

   initial begin : param_chk
      if (ADDR_W <= DATA_W) $fatal(1, "address must be wider than data");
      if (ALE_W < 1 || PSEN_W < 1 || STB_W < 1) $fatal(1, "strobe widths must be positive");
      if (ADDR_HOLD < 1 || ADDR_HOLD > PSEN_DLY) $fatal(1, "port must be free by fetch strobe");
      if (ADDR_HOLD >= STB_DLY) $fatal(1, "write data needs lead before write strobe");
   end

   ebus_kind_e               kind_q;
   logic [ADDR_W-1:0]        addr_q;
   logic [DATA_W-1:0]        wdata_q;
   logic                     busy, last, accept;
   logic [SLOT_W-1:0]        slot;
   logic                     drive_en, drive_data, sample;

   assign req_ready = !busy || last;
   assign accept    = osc_tick && req_valid && req_ready;
   assign addr_hi   = addr_q[ADDR_W-1:DATA_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         kind_q  <= KIND_FETCH;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         kind_q  <= ebus_kind_e'(req_kind);
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   ebus_slot_timer #(
      .SLOT_W(SLOT_W), .FETCH_LEN(FETCH_LEN), .DATA_LEN(DATA_LEN)
   ) u_timer (
      .clk(clk), .rst(rst), .osc_tick(osc_tick), .start(accept),
      .start_long(req_kind != 2'b00), .busy(busy), .slot(slot), .last(last)
   );

   ebus_strobe_gen #(
      .SLOT_W(SLOT_W), .ALE_W(ALE_W), .ADDR_HOLD(ADDR_HOLD), .PSEN_DLY(PSEN_DLY),
      .PSEN_W(PSEN_W), .STB_DLY(STB_DLY), .STB_W(STB_W)
   ) u_strobe (
      .busy(busy), .kind(kind_q), .slot(slot), .ale(ale), .fetch_n(fetch_n),
      .rd_n(rd_n), .wr_n(wr_n), .drive_en(drive_en), .drive_data(drive_data),
      .sample(sample)
   );

   ebus_ad_port #(
      .DATA_W(DATA_W), .DONE_ON_WRITE(DONE_ON_WRITE)
   ) u_port (
      .clk(clk), .rst(rst), .drive_en(drive_en), .drive_data(drive_data),
      .addr_lo(addr_q[DATA_W-1:0]), .wdata(wdata_q), .ad_in(ad_in),
      .capture(osc_tick && sample),
      .write_end(osc_tick && last && kind_is_write(kind_q)),
      .ad_out(ad_out), .ad_oe(ad_oe), .rsp_data(rsp_data), .rsp_valid(rsp_valid)
   );

   // R2
   ale_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      ale |-> (fetch_n && rd_n && wr_n && ad_oe));
   // R3 R4
   one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      $countones({!fetch_n, !rd_n, !wr_n}) <= 1);
   // R6
   rd_release_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_n || !fetch_n) |-> !ad_oe);
   // R5
   wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_n |-> ad_oe);
   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !accept) |=> $stable(addr_hi));
   // R9
   busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !last) |-> !req_ready);
endmodule

// File: tb/ebus_cycle_seq_bench.sv
module ebus_cycle_seq_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       osc_tick = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_kind = 2'b00;
   logic [15:0] req_addr = 16'h0;
   logic [7:0] req_wdata = 8'h0;
   logic       req_ready, ale, fetch_n, rd_n, wr_n, ad_oe, rsp_valid;
   logic [7:0] addr_hi, ad_out, ad_in, rsp_data;
   logic [7:0] lo_lat = 8'h0;

   int tests = 0;
   int fails = 0;

   // bench model state
   bit        m_busy = 0;
   int        m_slot = 0;
   int        m_kind = 0;
   logic [15:0] m_addr = 0;
   logic [7:0]  m_wdata = 0;
   bit        m_rsp = 0;
   logic [7:0]  m_rsp_data = 0;
   int        dir_kind = 0;

   always #2 clk = ~clk;

   ebus_cycle_seq u_ebus_cycle_seq (
      .clk(clk), .rst(rst), .osc_tick(osc_tick), .req_valid(req_valid),
      .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .ale(ale), .fetch_n(fetch_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
      .rsp_data(rsp_data), .rsp_valid(rsp_valid)
   );

   function automatic logic [7:0] dev_byte(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
   endfunction

   // external address latch and memory model
   always @(negedge ale) lo_lat = ad_out;
   assign ad_in = (!fetch_n || !rd_n) ? dev_byte({addr_hi, lo_lat}) : 8'h00;

   function automatic int cyc_len(input int k);
      return (k == 0) ? 6 : 12;
   endfunction

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %h expected %h (slot %0d kind %0d)", tag, got, exp, m_slot, m_kind);
      end
   endtask

   task automatic check_outputs();
      bit e_ale, e_fn, e_rn, e_wn, e_oe;
      logic [7:0] e_ad;
      e_ale = m_busy && m_slot < 2;
      e_fn  = !(m_busy && m_kind == 0 && m_slot >= 3 && m_slot <= 5);
      e_rn  = !(m_busy && (m_kind == 1 || m_kind == 3) && m_slot >= 5 && m_slot <= 10);
      e_wn  = !(m_busy && m_kind == 2 && m_slot >= 5 && m_slot <= 10);
      e_oe  = m_busy && (m_slot <= 2 || (m_kind == 2 && m_slot <= 11));
      e_ad  = (m_slot <= 2) ? m_addr[7:0] : m_wdata;
      if (!m_busy) begin
         chk("R1 ale idle", 16'(ale), 16'(0));
         chk("R1 strobes idle", 16'({fetch_n, rd_n, wr_n}), 16'(3'b111));
         chk("R1 port idle", 16'(ad_oe), 16'(0));
      end else begin
         chk("R2 ale", 16'(ale), 16'(e_ale));
         chk("R3 fetch_n", 16'(fetch_n), 16'(e_fn));
         chk("R4 rd_n", 16'(rd_n), 16'(e_rn));
         chk("R4 wr_n", 16'(wr_n), 16'(e_wn));
         if (m_kind == 2) chk("R5 ad_oe write", 16'(ad_oe), 16'(e_oe));
         else             chk("R6 ad_oe read", 16'(ad_oe), 16'(e_oe));
         if (e_oe) chk(m_slot <= 2 ? "R2 ad_out addr" : "R5 ad_out data", 16'(ad_out), 16'(e_ad));
         chk("R7 addr_hi", 16'(addr_hi), 16'(m_addr[15:8]));
      end
      chk("R9 req_ready", 16'(req_ready), 16'(!m_busy || m_slot == cyc_len(m_kind) - 1));
      chk("R8 rsp_valid", 16'(rsp_valid), 16'(m_rsp));
      if (m_rsp) chk("R8 rsp_data", 16'(rsp_data), 16'(m_rsp_data));
   endtask

   // model the coming clock edge from the inputs just driven
   task automatic model_step();
      bit rdy;
      rdy = !m_busy || m_slot == cyc_len(m_kind) - 1;
      m_rsp = 0;
      if (rst) begin
         m_busy = 0; m_slot = 0;
         return;
      end
      if (!osc_tick) return;
      if (m_busy && m_kind != 2 && m_slot == (m_kind == 0 ? 5 : 10)) begin
         m_rsp = 1;
         m_rsp_data = dev_byte(m_addr);
      end
      if (m_busy) begin
         if (m_slot == cyc_len(m_kind) - 1) begin m_busy = 0; m_slot = 0; end
         else m_slot++;
      end
      if (req_valid && rdy) begin
         m_busy = 1; m_slot = 0; m_kind = int'(req_kind);
         m_addr = req_addr; m_wdata = req_wdata;
         dir_kind = (dir_kind + 1) % 4;
      end
   endtask

   initial begin : watchdog
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd2718));
      // reset phase: inputs active but ignored (R1)
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check_outputs();
         osc_tick = 1'b1; req_valid = 1'b1; req_kind = 2'b10;
         model_step();
      end
      @(negedge clk);
      rst = 1'b0;
      model_step();
      // directed: every clock an oscillator tick, back-to-back cycles of each kind
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         check_outputs();
         osc_tick  = 1'b1;
         req_valid = 1'b1;
         req_kind  = 2'(dir_kind);
         req_addr  = (i < 60) ? 16'hFF00 + 16'(i) : 16'($urandom);
         req_wdata = 8'($urandom);
         model_step();
      end
      // directed: request without a tick never starts (R9)
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         check_outputs();
         osc_tick  = (i > 30);
         req_valid = (i > 20);
         req_kind  = 2'b01;
         req_addr  = 16'h0000;
         model_step();
      end
      // random: sparse ticks, requests while busy
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         check_outputs();
         osc_tick  = ($urandom % 3) != 0;
         req_valid = ($urandom % 3) == 0;
         req_kind  = 2'($urandom);
         req_addr  = 16'($urandom);
         req_wdata = 8'($urandom);
         model_step();
      end
      @(negedge clk);
      check_outputs();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule